// File: doc/BRIEF.md
# Bidirectional General-Purpose Pin Port

This block is an eight-bit general-purpose I/O port on a small register bus. Three registers control it: an output latch that holds the value to drive, a per-bit direction register, and a per-bit pull-up enable register. Software reads and writes these registers through a two-bit address, a write strobe, write data and a combinational read-data return.

On the pad side, every bit has an output value, an output enable, a pull-up request and an input value. A bit set as an output drives its latch value, and reading it returns the latch, not the pin. A bit set as an input is left undriven. It may request a pull-up, and reading it returns the pin level after a two-flop synchronizer. A parameter lists the bits that have no pull-up hardware. Those bits never request a pull-up and always read back 0 in the pull-up register.

Top module: `gpio_port`

## Requirements
- R1: After reset the latch, direction and pull-up registers are all 0, so `pad_oe`, `pad_pu` and `pad_out` are 0 and every pin is an input.
- R2: Writing address 1 sets the direction register. A 1 bit makes that pin an output and a 0 bit makes it an input. `pad_oe` follows the register from the clock edge that takes the write.
- R3: Writing address 0 updates the latch for every bit, whatever its direction. `pad_out` always equals the latch, and a latch write never changes `pad_oe`, so an input pin stays undriven.
- R4: Reading address 0 returns the latch value on output bits, whatever level `pad_in` shows.
- R5: Reading address 0 returns `pad_in` on input bits, delayed by two rising clock edges. After a single edge the read still shows the earlier level.
- R6: `pad_pu` for each bit is its pull-up register bit AND NOT its direction bit. A 1 in the pull-up register means pull-up enabled and a 0 means none.
- R7: Bits marked in `NO_PULL_MASK` read 0 at address 2 and never assert `pad_pu`, whatever value is written to them.
- R8: Reading address 1 returns the stored direction bits and address 2 returns the stored pull-up bits. Address 3 reads 0, and a write to it changes no register.
- R9: With `bus_we` low, nothing changes in any register, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronized inside the block |
| bus_addr | input | 2 | Register select: 0 latch/data, 1 direction, 2 pull-up, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Pin levels seen at the pads |
| pad_out | output | 8 | Value to drive on each pin |
| pad_oe | output | 8 | Drive enable per pin |
| pad_pu | output | 8 | Pull-up request per pin |

## Verification
A register write becomes visible at the pads and at the read port right after the rising edge that takes it, so the bench drives each write in the low phase and samples on the next falling edge. A change on `pad_in` reaches the data read only after two rising edges. The bench therefore changes the pins on a falling edge, checks one falling edge later that the old value is still returned, and checks the new value one edge after that. Reads are combinational, so the bench compares them shortly after setting the address, well away from any clock edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_reset_sync.sv
module gpio_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned      WIDTH        = 8,
  parameter logic [WIDTH-1:0] NO_PULL_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pull_q
);
  reg_sel_e         sel;
  logic             wr_latch, wr_dir, wr_pull;
  logic [WIDTH-1:0] latch_d, dir_d;

  assign sel = reg_sel_e'(bus_addr);

  always_comb begin
    wr_latch = bus_we && (sel == SEL_DATA);
    wr_dir   = bus_we && (sel == SEL_DIR);
    wr_pull  = bus_we && (sel == SEL_PULL);
    latch_d  = wr_latch ? bus_wdata : latch_q;
    dir_d    = wr_dir   ? bus_wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pull
    if (NO_PULL_MASK[i]) begin : g_absent
      assign pull_q[i] = 1'b0;
    end else begin : g_present
      logic bit_d, bit_q;
      assign bit_d = wr_pull ? bus_wdata[i] : bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign pull_q[i] = bit_q;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: bus_rdata = (dir_q & latch_q) | (~dir_q & pin_sync);
      SEL_DIR:  bus_rdata = dir_q;
      SEL_PULL: bus_rdata = pull_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned      WIDTH        = 8,
  parameter int unsigned      SYNC_STAGES  = 2,
  parameter logic [WIDTH-1:0] NO_PULL_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pu
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] latch_q, dir_q, pull_q;

  gpio_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_insync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .NO_PULL_MASK(NO_PULL_MASK)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .pin_sync  (pin_sync),
    .bus_rdata (bus_rdata),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .pull_q    (pull_q)
  );

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;
  assign pad_pu  = pull_q & ~dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned      WIDTH        = 8,
  parameter logic [WIDTH-1:0] NO_PULL_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic              bus_we,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_pu
);
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1) |=> (pad_oe == $past(bus_wdata)));

  a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0) |=> (pad_out == $past(bus_wdata) && $stable(pad_oe)));

  a_r4_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> ((bus_rdata & pad_oe) == (pad_out & pad_oe)));

  a_r6_pull_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  a_r7_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & NO_PULL_MASK) == '0);

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .NO_PULL_MASK(NO_PULL_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_pu    (pad_pu)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [7:0]  NOPU       = 8'h81;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_out, pad_oe, pad_pu;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.WIDTH(8), .SYNC_STAGES(2), .NO_PULL_MASK(NOPU)) u_gpio_port (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_rdata,
    .pad_in, .pad_out, .pad_oe, .pad_pu
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    rd(2'd1, v); check("R1 dir read", v, 8'h00);
    rd(2'd2, v); check("R1 pull read", v, 8'h00);
    rd(2'd0, v); check("R1 data read", v, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] v;
    wr(2'd1, 8'hF0);
    check("R2 pad_oe after write", pad_oe, 8'hF0);
    rd(2'd1, v); check("R8 dir readback", v, 8'hF0);
  endtask

  task automatic t_latch_and_reads();
    logic [7:0] v;
    wr(2'd0, 8'h5A);
    check("R3 pad_out equals latch", pad_out, 8'h5A);
    check("R3 pad_oe untouched", pad_oe, 8'hF0);
    pad_in = 8'hAF;
    @(negedge clk); @(negedge clk);
    rd(2'd0, v); check("R4 R5 mixed read", v, 8'h5F);
    @(negedge clk);
    pad_in = 8'h03;
    @(negedge clk);
    rd(2'd0, v); check("R5 one edge old value", v, 8'h5F);
    @(negedge clk);
    rd(2'd0, v); check("R5 two edges new value", v, 8'h53);
  endtask

  task automatic t_pullups();
    logic [7:0] v;
    wr(2'd2, 8'hFF);
    rd(2'd2, v); check("R7 missing pull bits read 0", v, 8'h7E);
    check("R6 pull gated by direction", pad_pu, 8'h0E);
    wr(2'd1, 8'h00);
    check("R6 R7 all inputs", pad_pu, 8'h7E);
    wr(2'd1, 8'hFF);
    check("R6 all outputs", pad_pu, 8'h00);
    wr(2'd2, 8'h24);
    wr(2'd1, 8'h0F);
    rd(2'd2, v); check("R8 pull readback", v, 8'h24);
    check("R6 mixed", pad_pu, 8'h20);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(2'd3, 8'hFF);
    rd(2'd3, v); check("R8 unmapped reads 0", v, 8'h00);
    rd(2'd1, v); check("R8 dir unchanged", v, 8'h0F);
    rd(2'd2, v); check("R8 pull unchanged", v, 8'h24);
    check("R8 latch unchanged", pad_out, 8'h5A);
  endtask

  task automatic t_no_we();
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'hAA; bus_we = 1'b0;
    @(negedge clk);
    check("R9 dir unchanged", pad_oe, 8'h0F);
    bus_addr = 2'd0;
    @(negedge clk);
    check("R9 latch unchanged", pad_out, 8'h5A);
    bus_addr = 2'd2;
    @(negedge clk);
    check("R9 pull unchanged", pad_pu, 8'h20);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_direction();
    t_latch_and_reads();
    t_pullups();
    t_unmapped();
    t_no_we();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule